// File: doc/BRIEF.md
# XOR Register Exchange Sequencer

The block holds two registers, X and Y, of the same parameterised width. Both feed one shared bitwise logic unit. In any cycle the result of that unit can be written into exactly one of the two registers, and the other register keeps its value.

A start pulse launches a fixed three-step program that exchanges X and Y with no scratch storage. The steps are: X is written with X^Y, then Y is written with X^Y, then X is written with X^Y. A one-cycle done pulse follows the program. While the block is idle, a single manual step can also be issued: the caller chooses one bitwise operation and the register that receives the result. A load transfer can be issued instead, and it writes both registers at once.

Both the load port and the manual step port use valid/ready. A transfer takes place on a clock edge where valid and ready are both high. The caller keeps valid and the payload steady until ready is seen, and ready never depends on the caller's own valid. While the exchange runs, both ready lines are low. When start is asserted in an idle cycle, it has priority over both ports, and the manual step has priority over a load.

Top module: `regswap_engine`

## Requirements
- R1: After reset, x_out and y_out are zero, and busy and done are low.
- R2: A load transfer (ld_valid and ld_ready high at an edge) makes x_out equal ld_x and y_out equal ld_y after that edge.
- R3: A start sampled while busy is low makes busy high for exactly the three cycles that follow that edge.
- R4: In the cycle after busy falls, x_out holds the value y_out had when start was accepted, and y_out holds the former x_out.
- R5: The exchange gives the same result when both registers hold equal values, and when either register is zero.
- R6: The steps can be seen at the ports. After the first busy edge, x_out is X0^Y0 and y_out is unchanged. After the second, y_out is X0. After the third, x_out is Y0.
- R7: done is high for exactly one cycle, the cycle in which busy has just fallen and the exchanged values are first visible.
- R8: A start asserted while busy is high neither lengthens busy nor produces an extra done pulse.
- R9: A manual step with op_sel 00=AND, 01=OR, 10=XOR or 11=PASS writes its result into X when op_to_x is 1 and into Y when op_to_x is 0. PASS copies the other register into the destination. The register that is not written holds its value.
- R10: op_ready is high exactly when busy is low and swap_start is low. ld_ready is high exactly when op_ready is high and op_valid is low. Loads and steps offered while busy do not change the registers.
- R11: In an idle cycle, start is accepted ahead of a manual step, and a manual step is accepted ahead of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | Load offer |
| ld_ready | output | 1 | Load accepted this cycle if valid |
| ld_x | input | W | Value for X |
| ld_y | input | W | Value for Y |
| op_valid | input | 1 | Manual step offer |
| op_ready | output | 1 | Manual step accepted this cycle if valid |
| op_sel | input | 2 | Bitwise operation code |
| op_to_x | input | 1 | 1 writes X, 0 writes Y |
| swap_start | input | 1 | Starts the exchange program |
| busy | output | 1 | Exchange program running |
| done | output | 1 | One-cycle pulse after the last step |
| x_out | output | W | Register X |
| y_out | output | W | Register Y |

## Verification
The exchange is run on distinct mixed-bit values, on equal values, and on a zero against all-ones pair. The distinct values show whether each step writes the correct register. The equal pair shows that the A^A=0 step is restored correctly and not lost. The zero against all-ones pair exposes a step that drops or inverts bits. Each manual operation is written in both directions, and PASS in particular separates the two write targets, because a swapped select copies the wrong register. An exchange disturbed by start, load and step offers while it runs, together with offers that collide in an idle cycle, shows whether the busy lockout and the priority order hold.

// File: rtl/regswap_pkg.sv
package regswap_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_XOR  = 2'b10,
    OP_PASS = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_X1   = 2'd1,
    ST_Y    = 2'd2,
    ST_X2   = 2'd3
  } step_e;

  // one bit of the shared logic unit; PASS copies the non-destination register
  function automatic logic bit_op(op_e op, logic xb, logic yb, logic to_x);
    case (op)
      OP_AND:  return xb & yb;
      OP_OR:   return xb | yb;
      OP_XOR:  return xb ^ yb;
      default: return to_x ? yb : xb;
    endcase
  endfunction

endpackage

// File: rtl/regswap_alu.sv
module regswap_alu
  import regswap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_x,
  input  logic [W-1:0] b_y,
  input  op_e          op,
  input  logic         to_x,
  output logic [W-1:0] res
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign res[i] = bit_op(op, a_x[i], b_y[i], to_x);
  end

endmodule

// File: rtl/regswap_ctrl.sv
module regswap_ctrl
  import regswap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       op_valid,
  input  logic       ld_valid,
  input  logic [1:0] op_sel_in,
  input  logic       op_to_x_in,
  output logic       busy,
  output logic       done,
  output logic       op_ready,
  output logic       ld_ready,
  output logic       ld_fire,
  output logic       wr_en,
  output logic       wr_to_x,
  output op_e        alu_op
);

  step_e st_q, st_d;
  logic  done_q;
  logic  start_fire, op_fire;

  assign busy       = (st_q != ST_IDLE);
  assign op_ready   = !busy && !start;
  assign ld_ready   = op_ready && !op_valid;
  assign start_fire = !busy && start;
  assign op_fire    = op_ready && op_valid;
  assign ld_fire    = ld_ready && ld_valid;
  assign done       = done_q;

  always_comb begin
    st_d    = st_q;
    alu_op  = op_e'(op_sel_in);
    wr_to_x = op_to_x_in;
    wr_en   = op_fire;
    case (st_q)
      ST_IDLE: if (start_fire) st_d = ST_X1;
      ST_X1: begin
        alu_op = OP_XOR; wr_to_x = 1'b1; wr_en = 1'b1; st_d = ST_Y;
      end
      ST_Y: begin
        alu_op = OP_XOR; wr_to_x = 1'b0; wr_en = 1'b1; st_d = ST_X2;
      end
      default: begin
        alu_op = OP_XOR; wr_to_x = 1'b1; wr_en = 1'b1; st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_X2);
    end
  end

endmodule

// File: rtl/regswap_regs.sv
module regswap_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_fire,
  input  logic [W-1:0] ld_x,
  input  logic [W-1:0] ld_y,
  input  logic         wr_en,
  input  logic         wr_to_x,
  input  logic [W-1:0] res,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (ld_fire) begin
      x_q <= ld_x;
      y_q <= ld_y;
    end else if (wr_en) begin
      if (wr_to_x) x_q <= res;
      else         y_q <= res;
    end
  end

endmodule

// File: rtl/regswap_engine.sv
module regswap_engine
  import regswap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_valid,
  output logic         ld_ready,
  input  logic [W-1:0] ld_x,
  input  logic [W-1:0] ld_y,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [1:0]   op_sel,
  input  logic         op_to_x,
  input  logic         swap_start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out
);

  logic         ld_fire, wr_en, wr_to_x;
  op_e          alu_op;
  logic [W-1:0] res;

  regswap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(swap_start), .op_valid(op_valid),
    .ld_valid(ld_valid), .op_sel_in(op_sel), .op_to_x_in(op_to_x),
    .busy(busy), .done(done), .op_ready(op_ready), .ld_ready(ld_ready),
    .ld_fire(ld_fire), .wr_en(wr_en), .wr_to_x(wr_to_x), .alu_op(alu_op)
  );

  regswap_alu #(.W(W)) u_alu (
    .a_x(x_out), .b_y(y_out), .op(alu_op), .to_x(wr_to_x), .res(res)
  );

  regswap_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .ld_x(ld_x), .ld_y(ld_y),
    .wr_en(wr_en), .wr_to_x(wr_to_x), .res(res), .x_q(x_out), .y_q(y_out)
  );

endmodule

// File: rtl/regswap_checker.sv
module regswap_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_valid,
  input logic         ld_ready,
  input logic [W-1:0] ld_x,
  input logic [W-1:0] ld_y,
  input logic         op_ready,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] x_out,
  input logic [W-1:0] y_out
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> (x_out == $past(ld_x) && y_out == $past(ld_y)));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 !busy);

  p_swapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (x_out == $past(y_out, 3) && y_out == $past(x_out, 3)));

  p_one_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(x_out) || $stable(y_out)));

  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_only_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ld_ready && !op_ready));

endmodule

bind regswap_engine regswap_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_x(ld_x), .ld_y(ld_y), .op_ready(op_ready), .busy(busy), .done(done),
  .x_out(x_out), .y_out(y_out)
);

// File: tb/regswap_engine_bench.sv
module regswap_engine_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_valid = 1'b0, op_valid = 1'b0, op_to_x = 1'b0, swap_start = 1'b0;
  logic [W-1:0] ld_x = '0, ld_y = '0;
  logic [1:0]   op_sel = 2'b00;
  logic         ld_ready, op_ready, busy, done;
  logic [W-1:0] x_out, y_out;

  regswap_engine #(.W(W)) u_regswap_engine (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_x(ld_x), .ld_y(ld_y), .op_valid(op_valid), .op_ready(op_ready),
    .op_sel(op_sel), .op_to_x(op_to_x), .swap_start(swap_start),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out)
  );

  always #2 clk = ~clk;

  typedef struct {
    int unsigned  due;
    logic [W-1:0] x, y;
    logic         b, d;
    string        tag;
  } exp_t;

  exp_t         q[$];
  int unsigned  cyc = 0;
  int           checks = 0, errors = 0;
  logic [W-1:0] mx = '0, my = '0;
  bit           finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic push(input int unsigned d, input logic [W-1:0] x, input logic [W-1:0] y,
                      input logic b, input logic dn, input string tag);
    exp_t e;
    e.due = cyc + d; e.x = x; e.y = y; e.b = b; e.d = dn; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare scoreboard items due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.due == cyc && x_out == e.x && y_out == e.y && busy == e.b && done == e.d, e.tag,
          $sformatf("x=%h y=%h busy=%b done=%b", x_out, y_out, busy, done),
          $sformatf("x=%h y=%h busy=%b done=%b", e.x, e.y, e.b, e.d));
    end
  end

  function automatic logic [W-1:0] model_op(input logic [1:0] s, input logic tx);
    case (s)
      2'b00:   return mx & my;
      2'b01:   return mx | my;
      2'b10:   return mx ^ my;
      default: return tx ? my : mx;
    endcase
  endfunction

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    ld_valid = 1'b1; ld_x = a; ld_y = b;
    #1 chk(ld_ready === 1'b1, "R10 ld_ready idle", $sformatf("%b", ld_ready), "1");
    push(1, a, b, 1'b0, 1'b0, "R2 load");
    mx = a; my = b;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] s, input logic tx);
    logic [W-1:0] r;
    r = model_op(s, tx);
    op_valid = 1'b1; op_sel = s; op_to_x = tx;
    #1 chk(op_ready === 1'b1, "R10 op_ready idle", $sformatf("%b", op_ready), "1");
    if (tx) mx = r; else my = r;
    push(1, mx, my, 1'b0, 1'b0, "R9 manual step");
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // collide: offer load and step with start (R11); disturb: offers during busy (R8, R10)
  task automatic do_swap(input bit collide, input bit disturb, input string tag);
    int unsigned c0;
    c0 = cyc;
    swap_start = 1'b1;
    if (collide) begin
      op_valid = 1'b1; op_sel = 2'b00; op_to_x = 1'b1;
      ld_valid = 1'b1; ld_x = 16'hDEAD; ld_y = 16'hBEEF;
      #1 chk(op_ready === 1'b0 && ld_ready === 1'b0, "R11 start wins",
             $sformatf("op_ready=%b ld_ready=%b", op_ready, ld_ready), "0 0");
    end
    push(1, mx, my, 1'b1, 1'b0, "R3 busy rises");
    push(2, mx ^ my, my, 1'b1, 1'b0, {"R6 step one ", tag});
    push(3, mx ^ my, mx, 1'b1, 1'b0, {"R6 step two ", tag});
    push(4, my, mx, 1'b0, 1'b1, {"R4 R7 swapped ", tag});
    push(5, my, mx, 1'b0, 1'b0, "R7 done single R8");
    @(negedge clk);
    swap_start = 1'b0; op_valid = 1'b0; ld_valid = 1'b0;
    if (disturb) begin
      swap_start = 1'b1; op_valid = 1'b1; op_sel = 2'b11; ld_valid = 1'b1;
      #1 chk(op_ready === 1'b0 && ld_ready === 1'b0, "R10 locked while busy",
             $sformatf("op_ready=%b ld_ready=%b", op_ready, ld_ready), "0 0");
      @(negedge clk);
      swap_start = 1'b0; op_valid = 1'b0; ld_valid = 1'b0;
    end
    while (cyc < c0 + 5) @(negedge clk);
    begin
      logic [W-1:0] t;
      t = mx; mx = my; my = t;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(x_out == '0 && y_out == '0, "R1 regs reset", $sformatf("%h %h", x_out, y_out), "0 0");
    chk(busy == 1'b0 && done == 1'b0, "R1 flags reset", $sformatf("%b %b", busy, done), "0 0");
    rst_n = 1'b1;
    @(negedge clk);

    do_load(16'hA5C3, 16'h0F0F);
    do_swap(1'b0, 1'b0, "distinct");
    do_op(2'b00, 1'b0);
    do_op(2'b01, 1'b1);
    do_op(2'b10, 1'b0);
    do_op(2'b11, 1'b1);
    do_op(2'b11, 1'b0);
    do_load(16'h1234, 16'h5678);
    do_op(2'b11, 1'b0);
    do_load(16'h1234, 16'h1234);
    do_swap(1'b0, 1'b0, "R5 equal");
    do_load(16'h0000, 16'hFFFF);
    do_swap(1'b0, 1'b0, "R5 zero");
    do_load(16'h0000, 16'h0000);
    do_swap(1'b0, 1'b0, "R5 both zero");
    do_load(16'h3C5A, 16'h9001);
    do_swap(1'b0, 1'b1, "R8 disturbed");
    do_swap(1'b1, 1'b0, "R11 collide");

    // R11: step beats load in an idle cycle
    op_valid = 1'b1; op_sel = 2'b10; op_to_x = 1'b1;
    ld_valid = 1'b1; ld_x = 16'hFFFF; ld_y = 16'hFFFF;
    #1 chk(ld_ready === 1'b0 && op_ready === 1'b1, "R11 step over load",
           $sformatf("ld_ready=%b op_ready=%b", ld_ready, op_ready), "0 1");
    mx = mx ^ my;
    push(1, mx, my, 1'b0, 1'b0, "R11 step applied load ignored");
    @(negedge clk);
    op_valid = 1'b0; ld_valid = 1'b0;

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule